// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Arbiter

This block picks the single interrupt that the program controller services next. It serves up to 32 sources. Each source has a pending input, and most have an enable bit and a 2-bit priority field. A 2-bit mask level from the status register filters the candidates. The winner is presented on a registered result stream. The result carries the source index, the level it won at, and its two-word vector address (twice the index).

Six sources have a fixed, unmaskable top level:

| Source | Index |
|---|---|
| Reset | 0 |
| Stack fault | 1 |
| Trace | 2 |
| Software trap | 3 |
| Nonmaskable pin | 15 |
| Illegal opcode | 31 |

Internal peripheral sources occupy indices 6–14 and 16–30. Their requests are captured in a sticky latch inside the block. When the controller accepts a result from one of these sources, the block pulses a per-source clear that drops the latch. The remaining sources, indices 4 and 5, are treated as already-conditioned pending levels.

The result is a valid/ready stream:
- While `res_valid` is high and `res_ready` is low, every result field holds still.
- A beat is accepted on a clock edge with both high. That same edge loads a fresh arbitration from which the accepted source is excluded.
- While `res_valid` is low, the block re-arbitrates on every edge.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `res_idx`, `res_vec`, `res_lvl` and `svc_clr` are all zero.
- R2: `res_vec` equals `res_idx` shifted left by one (a 6-bit word address, two words per vector) when `res_valid` is high. It is zero when `res_valid` is low.
- R3: Among the qualifying requests, the one with the highest effective level wins, and `res_lvl` reports that level.
- R4: A request whose effective level is below `sr_mask` is ignored, and a level equal to `sr_mask` still qualifies. Level 3 always qualifies, even with `sr_mask` = 3.
- R5: Sources 0, 1, 2, 3, 15 and 31 always have level 3. For these sources, `src_en` and `src_lvl` have no effect.
- R6: Every other source k takes its level from `src_lvl[2k+1:2k]`. A field value of 3 is treated as level 2.
- R7: Within one level, the lower index wins, with one exception at level 3. There the order is 0 first, then 31, then 15, then the remaining sources by ascending index.
- R8: A source other than the six fixed ones is not considered while its `src_en` bit is low.
- R9: For peripheral sources (6–14, 16–30), a one-cycle `src_req` pulse sets a pending latch that persists after the pulse. Clearing `src_en` does not erase the latch; it only keeps the source out of arbitration.
- R10: While `res_valid` is high and `res_ready` is low, the result is held. On an edge with both high, the next result is loaded on that edge, with the accepted source left out of that arbitration. With `res_valid` low, a result appears on the first edge after a qualifying request is seen.
- R11: During an accepted beat, `svc_clr` has exactly the winner's bit set if the winner is a peripheral source, and no bit set otherwise. The pulse clears that source's latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Pending level (fixed and external sources) or set pulse (peripheral sources) |
| src_en | input | 32 | Per-source enable, ignored for fixed sources |
| src_lvl | input | 64 | Per-source 2-bit priority field, source k at bits 2k+1:2k |
| sr_mask | input | 2 | Status-register interrupt mask level |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Controller accepts the result (next arbitration strobe) |
| res_idx | output | 5 | Winning source index |
| res_vec | output | 6 | Winning vector word address |
| res_lvl | output | 2 | Level of the winner |
| svc_clr | output | 32 | One-cycle clear for the serviced peripheral source |

## Verification
The hardest situations to reach from the ports involve time, not a single input pattern.

The first is a peripheral request that was captured while its source was disabled and must surface only once the source is enabled. The stimulus pulses that source's request with its enable low, waits several cycles, and then raises the enable.

The second is a held result that must not move when a higher-priority source arrives. The stimulus stalls `res_ready` while reset's request rises, and only then accepts the beat.

The third is an accepted source whose request level stays high, so it must be skipped by the very next arbitration. Two equal-level level-held sources are run with `res_ready` tied high, which makes them alternate on every edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP      = 2'd3;
  localparam lvl_t LVL_PROG_MAX = 2'd2;
endpackage

// File: rtl/irq_src_qual.sv
module irq_src_qual
  import irq_arb_pkg::*;
#(
  parameter int                   NUM_SRC     = 32,
  parameter logic [NUM_SRC-1:0]   FIXED_MASK  = 32'h8000_800F,
  parameter logic [NUM_SRC-1:0]   PERIPH_MASK = 32'h7FFF_7FC0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_req,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
  input  lvl_t                     sr_mask,
  input  logic [NUM_SRC-1:0]       clr,
  input  logic [NUM_SRC-1:0]       excl,
  output logic [NUM_SRC-1:0]       qual,
  output logic [NUM_SRC*LVL_W-1:0] eff_lvl
);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    lvl_t lvl_k;
    logic live_k;

    if (FIXED_MASK[k]) begin : g_fixed
      logic unused_fixed;
      assign unused_fixed = ^{src_en[k], src_lvl[k*LVL_W +: LVL_W]};
      assign lvl_k  = LVL_TOP;
      assign live_k = src_req[k];
    end else begin : g_prog
      lvl_t raw;
      logic pend;
      assign raw   = src_lvl[k*LVL_W +: LVL_W];
      assign lvl_k = (raw > LVL_PROG_MAX) ? LVL_PROG_MAX : raw;

      if (PERIPH_MASK[k]) begin : g_latch
        logic pend_q;
        always_ff @(posedge clk) begin
          if (!rst_n)          pend_q <= 1'b0;
          else if (src_req[k]) pend_q <= 1'b1;
          else if (clr[k])     pend_q <= 1'b0;
        end
        assign pend = pend_q;
      end else begin : g_direct
        logic unused_clr;
        assign unused_clr = clr[k];
        assign pend = src_req[k];
      end

      assign live_k = pend & src_en[k];
    end

    assign eff_lvl[k*LVL_W +: LVL_W] = lvl_k;
    assign qual[k] = live_k & (lvl_k >= sr_mask) & ~excl[k];
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int RESET_IDX   = 0,
  parameter int ILLEGAL_IDX = 31,
  parameter int NMI_IDX     = 15,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       qual,
  input  logic [NUM_SRC*LVL_W-1:0] eff_lvl,
  output logic                     any,
  output logic [IDX_W-1:0]         idx,
  output lvl_t                     lvl
);

  logic [NUM_SRC-1:0] cand;

  // Highest populated level.
  always_comb begin
    any = 1'b0;
    lvl = '0;
    for (int l = 0; l < (1 << LVL_W); l++) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (qual[i] && (eff_lvl[i*LVL_W +: LVL_W] == lvl_t'(l))) begin
          any = 1'b1;
          lvl = lvl_t'(l);
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      cand[i] = qual[i] && (eff_lvl[i*LVL_W +: LVL_W] == lvl);
  end

  // Lowest index first, then the top-level override order (last write wins).
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (cand[i]) idx = IDX_W'(i);
    if (cand[NMI_IDX])     idx = IDX_W'(NMI_IDX);
    if (cand[ILLEGAL_IDX]) idx = IDX_W'(ILLEGAL_IDX);
    if (cand[RESET_IDX])   idx = IDX_W'(RESET_IDX);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter logic [NUM_SRC-1:0] FIXED_MASK  = 32'h8000_800F,
  parameter logic [NUM_SRC-1:0] PERIPH_MASK = 32'h7FFF_7FC0,
  parameter int                 RESET_IDX   = 0,
  parameter int                 ILLEGAL_IDX = 31,
  parameter int                 NMI_IDX     = 15,
  localparam int                IDX_W       = $clog2(NUM_SRC),
  localparam int                VEC_W       = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_req,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
  input  logic [LVL_W-1:0]         sr_mask,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [IDX_W-1:0]         res_idx,
  output logic [VEC_W-1:0]         res_vec,
  output logic [LVL_W-1:0]         res_lvl,
  output logic [NUM_SRC-1:0]       svc_clr
);

  logic                     hs;
  logic                     load;
  logic [NUM_SRC-1:0]       excl;
  logic [NUM_SRC-1:0]       qual;
  logic [NUM_SRC*LVL_W-1:0] eff_lvl;
  logic                     win_any;
  logic [IDX_W-1:0]         win_idx;
  lvl_t                     win_lvl;

  assign hs      = res_valid & res_ready;
  assign load    = ~res_valid | res_ready;
  assign excl    = hs ? (NUM_SRC'(1) << res_idx) : '0;
  assign svc_clr = excl & PERIPH_MASK;

  irq_src_qual #(
    .NUM_SRC    (NUM_SRC),
    .FIXED_MASK (FIXED_MASK),
    .PERIPH_MASK(PERIPH_MASK)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_req(src_req),
    .src_en (src_en),
    .src_lvl(src_lvl),
    .sr_mask(sr_mask),
    .clr    (svc_clr),
    .excl   (excl),
    .qual   (qual),
    .eff_lvl(eff_lvl)
  );

  irq_pick #(
    .NUM_SRC    (NUM_SRC),
    .RESET_IDX  (RESET_IDX),
    .ILLEGAL_IDX(ILLEGAL_IDX),
    .NMI_IDX    (NMI_IDX)
  ) u_pick (
    .qual   (qual),
    .eff_lvl(eff_lvl),
    .any    (win_any),
    .idx    (win_idx),
    .lvl    (win_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_lvl   <= '0;
    end else if (load) begin
      res_valid <= win_any;
      res_idx   <= win_any ? win_idx : '0;
      res_lvl   <= win_any ? win_lvl : '0;
    end
  end

  assign res_vec = {res_idx, 1'b0};

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int                 NUM_SRC    = 32,
  parameter logic [NUM_SRC-1:0] FIXED_MASK = 32'h8000_800F,
  localparam int                IDX_W      = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         sr_mask,
  input logic               res_valid,
  input logic               res_ready,
  input logic [IDX_W-1:0]   res_idx,
  input logic [IDX_W:0]     res_vec,
  input logic [1:0]         res_lvl,
  input logic [NUM_SRC-1:0] svc_clr
);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_idx) && $stable(res_lvl)));

  // R4
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid || res_ready) |=> (!res_valid || res_lvl >= $past(sr_mask)));

  // R5
  fixed_top_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && FIXED_MASK[res_idx]) |-> (res_lvl == 2'd3));

  // R11
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_clr));

  // R11
  clr_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_clr) |-> (res_valid && res_ready && svc_clr[res_idx]));

  // R2
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_vec == '0 && res_lvl == 2'd0));

endmodule

bind irq_arbiter irq_arbiter_chk #(
  .NUM_SRC   (NUM_SRC),
  .FIXED_MASK(FIXED_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sr_mask  (sr_mask),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_idx  (res_idx),
  .res_vec  (res_vec),
  .res_lvl  (res_lvl),
  .svc_clr  (svc_clr)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_req, src_en;
  logic [63:0] src_lvl;
  logic [1:0]  sr_mask;
  logic        res_valid, res_ready;
  logic [4:0]  res_idx;
  logic [5:0]  res_vec;
  logic [1:0]  res_lvl;
  logic [31:0] svc_clr;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .src_lvl(src_lvl), .sr_mask(sr_mask), .res_valid(res_valid),
    .res_ready(res_ready), .res_idx(res_idx), .res_vec(res_vec),
    .res_lvl(res_lvl), .svc_clr(svc_clr)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [31:0] en;
    logic [1:0]  l4;
    logic [1:0]  l5;
    logic [1:0]  mask;
    logic        ev;
    logic [4:0]  eidx;
    logic [1:0]  elvl;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{32'h10,       32'h10, 2'd1, 2'd0, 2'd0, 1'b1, 5'd4,  2'd1}, // R3 single request
    '{32'h30,       32'h30, 2'd1, 2'd2, 2'd0, 1'b1, 5'd5,  2'd2}, // R3 higher level wins
    '{32'h30,       32'h30, 2'd2, 2'd2, 2'd0, 1'b1, 5'd4,  2'd2}, // R7 tie, lower index
    '{32'h10,       32'h10, 2'd1, 2'd0, 2'd2, 1'b0, 5'd0,  2'd0}, // R4 below mask
    '{32'h10,       32'h10, 2'd2, 2'd0, 2'd2, 1'b1, 5'd4,  2'd2}, // R4 equal to mask
    '{32'h10,       32'h00, 2'd2, 2'd0, 2'd0, 1'b0, 5'd0,  2'd0}, // R8 disabled
    '{32'h30,       32'h30, 2'd3, 2'd2, 2'd0, 1'b1, 5'd4,  2'd2}, // R6 field 3 acts as 2
    '{32'h10,       32'h10, 2'd3, 2'd0, 2'd3, 1'b0, 5'd0,  2'd0}, // R6 clamped below mask 3
    '{32'h12,       32'h10, 2'd2, 2'd0, 2'd3, 1'b1, 5'd1,  2'd3}, // R4 level 3 unmaskable
    '{32'h8002,     32'h00, 2'd0, 2'd0, 2'd0, 1'b1, 5'd15, 2'd3}, // R7 NMI over 1
    '{32'h8000_8000,32'h00, 2'd0, 2'd0, 2'd0, 1'b1, 5'd31, 2'd3}, // R7 illegal over NMI
    '{32'h8000_8001,32'h00, 2'd0, 2'd0, 2'd0, 1'b1, 5'd0,  2'd3}, // R7 reset first
    '{32'h0C,       32'h00, 2'd0, 2'd0, 2'd0, 1'b1, 5'd2,  2'd3}, // R7 plain index at level 3
    '{32'h08,       32'h00, 2'd1, 2'd1, 2'd3, 1'b1, 5'd3,  2'd3}, // R5 enable ignored
    '{32'h01,       32'h00, 2'd0, 2'd0, 2'd0, 1'b1, 5'd0,  2'd3}, // R2 valid with vector 0
    '{32'h00,       32'hFF, 2'd2, 2'd2, 2'd0, 1'b0, 5'd0,  2'd0}  // R2 nothing pending
  };

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_res(input string tag, input logic v, input logic [4:0] i, input logic [1:0] l);
    cmp({tag, " valid"}, 64'(res_valid), 64'(v));
    cmp({tag, " idx"},   64'(res_idx),   64'(v ? i : 5'd0));
    cmp({tag, " lvl"},   64'(res_lvl),   64'(v ? l : 2'd0));
    cmp({tag, " vec R2"}, 64'(res_vec),  64'(v ? {i, 1'b0} : 6'd0));
  endtask

  task automatic flush();
    @(negedge clk);
    src_req = '0; res_ready = 1'b1;
    @(posedge clk); @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_req = '0; src_en = '0; src_lvl = '0; sr_mask = '0; res_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check_res("R1 reset", 1'b0, 5'd0, 2'd0);
    cmp("R1 svc_clr", 64'(svc_clr), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      flush();
      @(negedge clk);
      res_ready = 1'b0;
      src_req = TBL[i].req; src_en = TBL[i].en; sr_mask = TBL[i].mask;
      src_lvl = '0; src_lvl[9:8] = TBL[i].l4; src_lvl[11:10] = TBL[i].l5;
      @(posedge clk); #1;
      check_res($sformatf("table[%0d]", i), TBL[i].ev, TBL[i].eidx, TBL[i].elvl);
    end
    flush();

    // R9 peripheral latch captured while disabled
    @(negedge clk);
    res_ready = 1'b0; src_en = '0; src_lvl = '0; sr_mask = 2'd0;
    src_req[20] = 1'b1;
    @(negedge clk); src_req[20] = 1'b0;
    repeat (3) @(posedge clk); #1;
    cmp("R9 disabled latch not served", 64'(res_valid), 64'd0);
    @(negedge clk); src_en[20] = 1'b1; src_lvl[41:40] = 2'd1;
    @(posedge clk); #1;
    check_res("R9 latch surfaces", 1'b1, 5'd20, 2'd1);

    // R10 hold while stalled although reset arrives
    @(negedge clk); src_req[0] = 1'b1;
    repeat (2) @(posedge clk); #1;
    check_res("R10 hold", 1'b1, 5'd20, 2'd1);

    // R11 clear pulse on accepted peripheral beat
    @(negedge clk); res_ready = 1'b1; #1;
    cmp("R11 clr peripheral", 64'(svc_clr), 64'h0010_0000);
    @(posedge clk); #1;
    check_res("R10 next after accept", 1'b1, 5'd0, 2'd3);
    @(negedge clk); src_req[0] = 1'b0; #1;
    cmp("R11 no clr for fixed", 64'(svc_clr), 64'd0);
    @(posedge clk); #1;
    cmp("R11 latch cleared", 64'(res_valid), 64'd0);

    // R10 accepted level-held source skipped in the next arbitration
    @(negedge clk);
    src_en[5:4] = 2'b11; src_lvl[11:8] = 4'b1010; src_req[5:4] = 2'b11;
    @(posedge clk); #1;
    check_res("R7 first pick", 1'b1, 5'd4, 2'd2);
    @(posedge clk); #1;
    check_res("R10 excluded winner", 1'b1, 5'd5, 2'd2);
    @(posedge clk); #1;
    check_res("R10 alternate back", 1'b1, 5'd4, 2'd2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule